// File: doc/BRIEF.md
# Pixel Format Unpacker With Palette

This block sits between a framebuffer word fetcher and a display pipeline. It takes a stream of 32-bit words under valid/ready flow control and emits a stream of 24-bit RGB pixels, also under valid/ready. A two-bit format input chooses how each word is cut up. It can hold four 8-bit palette indices, two 16-bit 5-6-5 pixels, or one direct-colour pixel. A blank setting emits black and fetches nothing.

In the indexed format every byte selects one of 256 stored colours. The table is loaded through a single write port. Each write carries the entry number and the colour together in one 32-bit word. Narrow 5-6-5 channels are widened to 8 bits, so the output always has the same layout: red in bits 23:16, green in 15:8 and blue in 7:0.

Top module: `pxu_top`

## Requirements
- R1: After reset `pix_valid_o` is 0, and `word_ready_o` is 1 while the format is not blank.
- R2: Format code 1 (indexed) splits each word into four bytes and emits them most significant byte first. Each byte selects one of 256 table entries, and the entry's colour is output.
- R3: A table write word carries the entry number in bits 31:24, red in 23:16, green in 15:8 and blue in 7:0. Entry 255 is reachable.
- R4: A table write accepted at a clock edge is used by lookups made at later edges, and a lookup made at the same edge returns the previous colour. An indexed pixel shown two or more cycles after the write therefore has the new colour.
- R5: Format code 2 (5-6-5) splits each word into two halfwords and emits the upper one first. Red comes from bits 15:11, green from 10:5 and blue from 4:0.
- R6: A 5-bit channel widens to {c[4:0], c[4:2]} and a 6-bit channel widens to {c[5:0], c[5:4]}.
- R7: Format code 3 (direct) emits one pixel per word: red from bits 23:16, green from 15:8 and blue from 7:0. Bits 31:24 have no effect.
- R8: Format code 0 (blank) keeps `word_ready_o` at 0 and emits pixels of value 0 whenever the output may advance.
- R9: While `pix_valid_o` is 1 and `pix_ready_i` is 0, the pixel is held unchanged. No pixel of an accepted word is lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_i | input | 2 | Format code: 0 blank, 1 indexed, 2 5-6-5, 3 direct |
| word_valid_i | input | 1 | Input word is offered |
| word_ready_o | output | 1 | Block accepts the offered word this cycle |
| word_i | input | 32 | Framebuffer word |
| pal_we_i | input | 1 | Table write strobe |
| pal_wdata_i | input | 32 | Table write: entry in 31:24, colour in 23:0 |
| pix_valid_o | output | 1 | Output pixel is valid |
| pix_ready_i | input | 1 | Consumer takes the pixel |
| pix_rgb_o | output | 24 | Pixel colour, red 23:16, green 15:8, blue 7:0 |

## Verification
The assertions assume that `fmt_i` does not change while a fetched word still has pixels left to emit. Under that assumption the lane count always stays below the lane count of the current format. The bench changes the format only after every pixel of the previous word has been collected and the output has drained. The palette-timing case lines up a table write with the edge at which the same entry is looked up, and holds the write strobe for exactly one cycle.

// File: rtl/pxu_pkg.sv
package pxu_pkg;

  typedef enum logic [1:0] {
    FMT_BLANK  = 2'd0,
    FMT_PAL8   = 2'd1,
    FMT_RGB565 = 2'd2,
    FMT_RGB888 = 2'd3
  } fmt_e;

  localparam int WORD_W = 32;
  localparam int RGB_W  = 24;
  localparam int LANE_W = 2;

  // Number of pixels carried by one word in a given format.
  function automatic logic [2:0] lanes_of(input logic [1:0] f);
    case (f)
      2'd1:    lanes_of = 3'd4;
      2'd2:    lanes_of = 3'd2;
      default: lanes_of = 3'd1;
    endcase
  endfunction

  // Widen a 5-bit channel by copying its top bits into the low end.
  function automatic logic [7:0] widen5(input logic [4:0] c);
    widen5 = {c, c[4:2]};
  endfunction

  // Widen a 6-bit channel by copying its top bits into the low end.
  function automatic logic [7:0] widen6(input logic [5:0] c);
    widen6 = {c, c[5:4]};
  endfunction

  function automatic logic [23:0] expand565(input logic [15:0] h);
    expand565 = {widen5(h[15:11]), widen6(h[10:5]), widen5(h[4:0])};
  endfunction

endpackage

// File: rtl/pxu_palette.sv
module pxu_palette #(
  parameter int IDX_W = 8,
  parameter int COL_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [COL_W-1:0] wr_col,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [COL_W-1:0] rd_col
);
  localparam int DEPTH = 1 << IDX_W;

  logic [COL_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wr_idx] <= wr_col;
  end

  // The read is combinational and sees the stored value. A write and a
  // lookup at the same edge therefore give the old colour.
  assign rd_col = mem[rd_idx];

  // R3: the colour lands in the entry that the write word names
  p_write_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> mem[$past(wr_idx)] == $past(wr_col));

endmodule

// File: rtl/pxu_word_buf.sv
module pxu_word_buf
  import pxu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        fmt,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [W-1:0]      in_data,
  input  logic              take,
  output logic              buf_valid,
  output logic [W-1:0]      buf_word,
  output logic [LANE_W-1:0] lane,
  output logic              last_lane
);
  logic       in_fire;
  logic [2:0] lane_next;

  assign lane_next = {1'b0, lane} + 3'd1;
  assign last_lane = (lane_next == lanes_of(fmt));
  assign in_ready  = (fmt != FMT_BLANK) && (!buf_valid || (take && last_lane));
  assign in_fire   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_valid <= 1'b0;
      buf_word  <= '0;
      lane      <= '0;
    end else begin
      if (take) begin
        if (last_lane) begin
          lane      <= '0;
          buf_valid <= 1'b0;
        end else begin
          lane <= lane_next[LANE_W-1:0];
        end
      end
      if (in_fire) begin
        buf_word  <= in_data;
        buf_valid <= 1'b1;
      end
    end
  end

  // R2: the lane count stays below the lane count of the format
  p_lane_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    buf_valid |-> ({1'b0, lane} < lanes_of(fmt)));

  // R9: an accepted word is held until its lanes are used up
  p_word_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_valid && !take) |=> buf_valid && $stable(buf_word) && $stable(lane));

  // R8: the blank format fetches nothing
  p_blank_no_fetch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt == FMT_BLANK) |-> !in_ready);

endmodule

// File: rtl/pxu_lane_decode.sv
module pxu_lane_decode
  import pxu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [1:0]        fmt,
  input  logic [W-1:0]      word,
  input  logic [LANE_W-1:0] lane,
  output logic [7:0]        pal_idx,
  output logic [RGB_W-1:0]  direct_rgb
);
  localparam int NBYTE = W / 8;
  localparam int NHALF = W / 16;

  logic [7:0]  bytes [NBYTE];
  logic [15:0] halves [NHALF];

  // Lane 0 is the most significant piece: the first pixel on screen.
  genvar g;
  generate
    for (g = 0; g < NBYTE; g++) begin : g_byte
      assign bytes[g] = word[W-1-8*g -: 8];
    end
    for (g = 0; g < NHALF; g++) begin : g_half
      assign halves[g] = word[W-1-16*g -: 16];
    end
  endgenerate

  assign pal_idx = bytes[lane];

  always_comb begin
    case (fmt)
      FMT_RGB565: direct_rgb = expand565(halves[lane[0]]);
      FMT_RGB888: direct_rgb = word[23:0];
      default:    direct_rgb = '0;
    endcase
  end

endmodule

// File: rtl/pxu_top.sv
module pxu_top
  import pxu_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  fmt_i,
  input  logic        word_valid_i,
  output logic        word_ready_o,
  input  logic [31:0] word_i,
  input  logic        pal_we_i,
  input  logic [31:0] pal_wdata_i,
  output logic        pix_valid_o,
  input  logic        pix_ready_i,
  output logic [23:0] pix_rgb_o
);
  localparam int IDX_W = 8;

  logic              out_adv;
  logic              lane_take;
  logic              buf_valid;
  logic [WORD_W-1:0] buf_word;
  logic [LANE_W-1:0] lane;
  logic              last_lane;
  logic [IDX_W-1:0]  pal_idx;
  logic [RGB_W-1:0]  pal_col;
  logic [RGB_W-1:0]  direct_rgb;
  logic              blank;

  assign blank     = (fmt_i == FMT_BLANK);
  assign out_adv   = !pix_valid_o || pix_ready_i;
  assign lane_take = out_adv && buf_valid && !blank;

  pxu_word_buf #(.W(WORD_W)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .fmt       (fmt_i),
    .in_valid  (word_valid_i),
    .in_ready  (word_ready_o),
    .in_data   (word_i),
    .take      (lane_take),
    .buf_valid (buf_valid),
    .buf_word  (buf_word),
    .lane      (lane),
    .last_lane (last_lane)
  );

  pxu_lane_decode #(.W(WORD_W)) u_dec (
    .fmt        (fmt_i),
    .word       (buf_word),
    .lane       (lane),
    .pal_idx    (pal_idx),
    .direct_rgb (direct_rgb)
  );

  pxu_palette #(.IDX_W(IDX_W), .COL_W(RGB_W)) u_pal (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (pal_we_i),
    .wr_idx (pal_wdata_i[31:24]),
    .wr_col (pal_wdata_i[23:0]),
    .rd_idx (pal_idx),
    .rd_col (pal_col)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_valid_o <= 1'b0;
      pix_rgb_o   <= '0;
    end else if (out_adv) begin
      if (blank) begin
        pix_valid_o <= 1'b1;
        pix_rgb_o   <= '0;
      end else if (buf_valid) begin
        pix_valid_o <= 1'b1;
        pix_rgb_o   <= (fmt_i == FMT_PAL8) ? pal_col : direct_rgb;
      end else begin
        pix_valid_o <= 1'b0;
      end
    end
  end

  // R9: a stalled pixel keeps its value
  p_hold_stalled_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid_o && !pix_ready_i) |=> pix_valid_o && $stable(pix_rgb_o));

  // R8: the blank format sends black
  p_blank_black_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (blank && out_adv) |=> pix_valid_o && (pix_rgb_o == '0));

  // R9: a lane is used only when a pixel is loaded
  p_take_loads_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lane_take |=> pix_valid_o);

endmodule

// File: tb/pxu_top_tb.sv
module pxu_top_tb;
  localparam int PERIOD = 10;
  localparam int NVEC   = 6;

  typedef struct packed {
    logic [1:0]  fmt;
    logic [31:0] word;
    logic [2:0]  n;
    logic [95:0] exp;   // pixel 0 in bits 95:72
  } vec_t;

  // The palette is loaded with entry i = {i, ~i, i ^ 8'h5A}.
  localparam vec_t VECS [NVEC] = '{
    '{2'd1, 32'h0001FE80, 3'd4, {24'h00FF5A, 24'h01FE5B, 24'hFE01A4, 24'h807FDA}},
    '{2'd1, 32'hFF7F0155, 3'd4, {24'hFF00A5, 24'h7F8025, 24'h01FE5B, 24'h55AA0F}},
    '{2'd2, 32'hF80007E0, 3'd2, {24'hFF0000, 24'h00FF00, 48'h0}},
    '{2'd2, 32'h001F8410, 3'd2, {24'h0000FF, 24'h848284, 48'h0}},
    '{2'd3, 32'hAB123456, 3'd1, {24'h123456, 72'h0}},
    '{2'd3, 32'h00FFFFFF, 3'd1, {24'hFFFFFF, 72'h0}}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  fmt_i = 2'd1;
  logic        word_valid_i = 1'b0;
  logic        word_ready_o;
  logic [31:0] word_i = '0;
  logic        pal_we_i = 1'b0;
  logic [31:0] pal_wdata_i = '0;
  logic        pix_valid_o;
  logic        pix_ready_i = 1'b1;
  logic [23:0] pix_rgb_o;

  int checks = 0;
  int errors = 0;

  always #(PERIOD/2) clk = ~clk;

  pxu_top u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .fmt_i        (fmt_i),
    .word_valid_i (word_valid_i),
    .word_ready_o (word_ready_o),
    .word_i       (word_i),
    .pal_we_i     (pal_we_i),
    .pal_wdata_i  (pal_wdata_i),
    .pix_valid_o  (pix_valid_o),
    .pix_ready_i  (pix_ready_i),
    .pix_rgb_o    (pix_rgb_o)
  );

  function automatic logic [23:0] pal_col(input logic [7:0] i);
    return {i, ~i, i ^ 8'h5A};
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic pal_write(input logic [7:0] idx, input logic [23:0] col);
    @(negedge clk);
    pal_we_i = 1'b1;
    pal_wdata_i = {idx, col};
    @(negedge clk);
    pal_we_i = 1'b0;
  endtask

  task automatic push_word(input logic [31:0] w);
    logic acc;
    @(negedge clk);
    word_valid_i = 1'b1;
    word_i = w;
    acc = 1'b0;
    while (!acc) begin
      acc = word_ready_o;
      @(negedge clk);
    end
    word_valid_i = 1'b0;
  endtask

  task automatic take_pixel(input string tag, input logic [23:0] exp);
    while (!pix_valid_o) @(negedge clk);
    check(tag, {8'h0, pix_rgb_o}, {8'h0, exp});
    @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 100000);
    errors++;
    $display("FAIL watchdog got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 valid", {31'h0, pix_valid_o}, 32'h0);
    check("R1 ready", {31'h0, word_ready_o}, 32'h1);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: load every entry, including 255
    for (int i = 0; i < 256; i++) pal_write(i[7:0], pal_col(i[7:0]));

    // Walk the vector table (R2 R3 R5 R6 R7)
    for (int v = 0; v < NVEC; v++) begin
      fmt_i = VECS[v].fmt;
      push_word(VECS[v].word);
      for (int p = 0; p < int'(VECS[v].n); p++)
        take_pixel($sformatf("R2/R5/R6/R7 vec%0d pix%0d", v, p),
                   VECS[v].exp[95-24*p -: 24]);
    end

    // R8: blank format
    @(negedge clk);
    fmt_i = 2'd0;
    word_valid_i = 1'b1;
    word_i = 32'h12345678;
    repeat (3) @(negedge clk);
    check("R8 ready", {31'h0, word_ready_o}, 32'h0);
    check("R8 valid", {31'h0, pix_valid_o}, 32'h1);
    check("R8 black", {8'h0, pix_rgb_o}, 32'h0);
    word_valid_i = 1'b0;
    fmt_i = 2'd2;
    repeat (2) @(negedge clk);
    check("R8 no word taken", {31'h0, pix_valid_o}, 32'h0);

    // R9: back-pressure holds the pixel and loses nothing
    pix_ready_i = 1'b0;
    push_word(32'hF80007E0);
    while (!pix_valid_o) @(negedge clk);
    repeat (3) begin
      check("R9 hold", {8'h0, pix_rgb_o}, 32'h00FF0000);
      @(negedge clk);
    end
    pix_ready_i = 1'b1;
    take_pixel("R9 pix0", 24'hFF0000);
    take_pixel("R9 pix1", 24'h00FF00);
    repeat (2) @(negedge clk);
    check("R9 drained", {31'h0, pix_valid_o}, 32'h0);

    // R4: a write and a same-edge lookup of entry 0x33
    fmt_i = 2'd1;
    pix_ready_i = 1'b0;
    push_word(32'h33333333);
    while (!pix_valid_o) @(negedge clk);
    check("R4 pix0 old", {8'h0, pix_rgb_o}, {8'h0, pal_col(8'h33)});
    pal_we_i = 1'b1;
    pal_wdata_i = {8'h33, 24'hC0FFEE};
    pix_ready_i = 1'b1;
    @(negedge clk);
    pal_we_i = 1'b0;
    check("R4 pix1 same edge old", {8'h0, pix_rgb_o}, {8'h0, pal_col(8'h33)});
    @(negedge clk);
    check("R4 pix2 new", {8'h0, pix_rgb_o}, 32'h00C0FFEE);
    @(negedge clk);
    check("R4 pix3 new", {8'h0, pix_rgb_o}, 32'h00C0FFEE);
    @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule